// File: doc/BRIEF.md
# I/O Translation Unit Control Register File

This block is the software-visible register file of an I/O address-translation unit. A processor reaches it over a simple word-wide register bus, which carries a word index, a write strobe, a read strobe, write data and read data. Each register applies its own write mask, and some also force selected bits to one. The block exports two values to the translator: the start address of the translation window, which comes from a 3-bit range code in the control register, and the page-table base. It also keeps a fault interrupt line.

The translator has a separate fault-capture port. A pulse on this port loads the fault status word and the faulting page address, and it raises the interrupt. Software clears the interrupt by reading or writing either fault register. The flush registers only hold what is written to them; no flush action takes place.

The bus addresses words, not bytes: a word index equals the byte offset divided by four. Reads are combinational, so `bus_rdata` reflects `bus_widx` in the same cycle. A register that is written shows its new value from the cycle after the write edge.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset the registers hold these values: control = VERSION & 0xFF000000; fault status = 0x00800000; arbiter-enable (word 0x402) = 0x00000003; arbitration-enable (word 0x800) = 0x00000008; mask-ID (word 0xC06) = 0x23000000. Every other register is 0, `win_start` is 0 and `irq` is 0.
- R2: A write to control (word 0x000) stores `wdata & 0x1D` (range code in bits 4:2, enable in bit 0) ORed with `VERSION & 0xFF000000`.
- R3: A control write sets `win_start` to 2^32 − (16 MB << code), where code = `wdata[4:2]`. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. `win_start` changes only on a control write.
- R4: Table base (word 0x001) stores `wdata & 0x07FFFC00` and drives `tbl_base`. The TLB-flush register (word 0x005) and the page-flush register (word 0x006) store the full word.
- R5: Fault status (word 0x400) stores `(wdata & 0xFF0FFFFF) | 0x00800000`.
- R6: Fault address (word 0x401) stores the full word. A bus read or write of word 0x400 or word 0x401 clears `irq` on the next edge, unless a capture happens in the same cycle.
- R7: Arbiter-enable stores `(wdata & 0x801F000F) | 0x1`.
- R8: Each of the four slot configuration registers (words 0x404 to 0x407) stores `wdata & 0x00010003`. A write to one slot leaves the others unchanged.
- R9: Arbitration-enable stores `(wdata & 0x001F0000) | 0x8`.
- R10: A mask-ID write ORs `wdata[23:0]` into the register. Bits 31:24 never change, and no bit ever clears.
- R11: A capture pulse loads fault status with 0xC0820000 when `flt_write` = 1, or 0xC0860000 when it is 0. It loads fault address with `flt_addr` and sets `irq` on the next edge. In the same cycle, a capture overrides a bus write to either fault register and a bus access that would clear the interrupt.
- R12: An unlisted word index below SCRATCH_WORDS (16) stores and returns the full written word. Any other unlisted index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_widx | input | 12 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used only for interrupt clearing) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_widx` |
| flt_valid | input | 1 | Fault-capture pulse from the translator |
| flt_write | input | 1 | Faulting access was a write |
| flt_addr | input | 32 | Faulting page address |
| irq | output | 1 | Fault interrupt |
| win_start | output | 32 | Start address of the translation window |
| tbl_base | output | 32 | Page-table base register value |

## Verification
Two events can land in the same cycle: a capture pulse from the translator and a bus access to a fault register. The bench provokes this by driving `flt_valid` together with a bus write of zero to fault status, and again together with a read of fault address. It then requires that fault status holds the captured word, not the written one, that fault address holds `flt_addr`, and that `irq` stays high. A later bus access alone must then clear the interrupt.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  localparam int IDX_W = 12;

  localparam int IX_CTRL   = 'h000;
  localparam int IX_BASE   = 'h001;
  localparam int IX_TLBF   = 'h005;
  localparam int IX_PGF    = 'h006;
  localparam int IX_FSTAT  = 'h400;
  localparam int IX_FADDR  = 'h401;
  localparam int IX_ARBM   = 'h402;
  localparam int IX_SLOT0  = 'h404;
  localparam int IX_ARBSB  = 'h800;
  localparam int IX_MASKID = 'h C06;

  localparam logic [31:0] M_CTRL   = 32'h0000_001D;
  localparam logic [31:0] M_VER    = 32'hFF00_0000;
  localparam logic [31:0] M_BASE   = 32'h07FF_FC00;
  localparam logic [31:0] M_FSTAT  = 32'hFF0F_FFFF;
  localparam logic [31:0] F_FSTAT  = 32'h0080_0000;
  localparam logic [31:0] M_ARBM   = 32'h801F_000F;
  localparam logic [31:0] F_ARBM   = 32'h0000_0001;
  localparam logic [31:0] R_ARBM   = 32'h0000_0003;
  localparam logic [31:0] M_SLOT   = 32'h0001_0003;
  localparam logic [31:0] M_ARBSB  = 32'h001F_0000;
  localparam logic [31:0] F_ARBSB  = 32'h0000_0008;
  localparam logic [31:0] M_MASKID = 32'h00FF_FFFF;
  localparam logic [31:0] R_MASKID = 32'h2300_0000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF, SEL_FSTAT, SEL_FADDR,
    SEL_ARBM, SEL_SLOT, SEL_ARBSB, SEL_MASKID, SEL_SCRATCH
  } sel_e;

  function automatic logic [31:0] apply_mask(logic [31:0] w, logic [31:0] m,
                                             logic [31:0] f);
    return (w & m) | f;
  endfunction

  // Window covers the top (16 MB << code) bytes of the 32-bit space.
  function automatic logic [31:0] window_start(logic [2:0] code);
    return 32'hFFFF_FFFF << (5'd24 + {2'b00, code});
  endfunction

  // Error, late-error, forced bit 23 and address-valid; read flag when not a write.
  function automatic logic [31:0] fault_word(logic is_write);
    return 32'hC082_0000 | (is_write ? 32'h0 : 32'h0004_0000);
  endfunction

endpackage

// File: rtl/xrf_decode.sv
module xrf_decode
  import xrf_pkg::*;
#(
  parameter int SLOTS         = 4,
  parameter int SCRATCH_WORDS = 16
) (
  input  logic [IDX_W-1:0] idx,
  output sel_e             sel
);
  always_comb begin
    sel = SEL_NONE;
    if (int'(idx) == IX_CTRL)                       sel = SEL_CTRL;
    else if (int'(idx) == IX_BASE)                  sel = SEL_BASE;
    else if (int'(idx) == IX_TLBF)                  sel = SEL_TLBF;
    else if (int'(idx) == IX_PGF)                   sel = SEL_PGF;
    else if (int'(idx) == IX_FSTAT)                 sel = SEL_FSTAT;
    else if (int'(idx) == IX_FADDR)                 sel = SEL_FADDR;
    else if (int'(idx) == IX_ARBM)                  sel = SEL_ARBM;
    else if (int'(idx) >= IX_SLOT0 &&
             int'(idx) <  IX_SLOT0 + SLOTS)         sel = SEL_SLOT;
    else if (int'(idx) == IX_ARBSB)                 sel = SEL_ARBSB;
    else if (int'(idx) == IX_MASKID)                sel = SEL_MASKID;
    else if (int'(idx) < SCRATCH_WORDS)             sel = SEL_SCRATCH;
  end
endmodule

// File: rtl/xrf_window.sv
module xrf_window
  import xrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  code,
  output logic [31:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    start_q <= '0;
    else if (load) start_q <= window_start(code);
  end
endmodule

// File: rtl/xrf_fault.sv
module xrf_fault
  import xrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic        cap_write,
  input  logic [31:0] cap_addr,
  input  logic        wr_stat,
  input  logic        wr_addr,
  input  logic        touch,
  input  logic [31:0] wdata,
  output logic [31:0] stat_q,
  output logic [31:0] addr_q,
  output logic        irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= F_FSTAT;
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else if (cap_valid) begin
      stat_q <= fault_word(cap_write);
      addr_q <= cap_addr;
      irq_q  <= 1'b1;
    end else begin
      if (wr_stat) stat_q <= apply_mask(wdata, M_FSTAT, F_FSTAT);
      if (wr_addr) addr_q <= wdata;
      if (touch)   irq_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xrf_pkg::*;
#(
  parameter logic [31:0] VERSION       = 32'h0500_0000,
  parameter int          SLOTS         = 4,
  parameter int          SCRATCH_WORDS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] bus_widx,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             flt_valid,
  input  logic             flt_write,
  input  logic [31:0]      flt_addr,
  output logic             irq,
  output logic [31:0]      win_start,
  output logic [31:0]      tbl_base
);
  localparam int          SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int          SCR_W  = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [31:0] VER_BITS = VERSION & M_VER;

  sel_e sel;

  // Named event wires, observed by the checker.
  logic ctrl_wr, fault_touch;

  logic [31:0] ctrl_q, base_q, tlbf_q, pgf_q, arbm_q, arbsb_q, maskid_q;
  logic [31:0] fstat_q, faddr_q;
  logic [31:0] slot_q    [SLOTS];
  logic [31:0] scratch_q [SCRATCH_WORDS];

  xrf_decode #(.SLOTS(SLOTS), .SCRATCH_WORDS(SCRATCH_WORDS)) u_dec (
    .idx (bus_widx),
    .sel (sel)
  );

  assign ctrl_wr     = bus_wr && sel == SEL_CTRL;
  assign fault_touch = (bus_wr || bus_rd) && (sel == SEL_FSTAT || sel == SEL_FADDR);

  xrf_window u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctrl_wr),
    .code    (bus_wdata[4:2]),
    .start_q (win_start)
  );

  xrf_fault u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (flt_valid),
    .cap_write (flt_write),
    .cap_addr  (flt_addr),
    .wr_stat   (bus_wr && sel == SEL_FSTAT),
    .wr_addr   (bus_wr && sel == SEL_FADDR),
    .touch     (fault_touch),
    .wdata     (bus_wdata),
    .stat_q    (fstat_q),
    .addr_q    (faddr_q),
    .irq_q     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= VER_BITS;
      base_q   <= '0;
      tlbf_q   <= '0;
      pgf_q    <= '0;
      arbm_q   <= R_ARBM;
      arbsb_q  <= F_ARBSB;
      maskid_q <= R_MASKID;
    end else if (bus_wr) begin
      case (sel)
        SEL_CTRL:   ctrl_q   <= apply_mask(bus_wdata, M_CTRL, VER_BITS);
        SEL_BASE:   base_q   <= apply_mask(bus_wdata, M_BASE, '0);
        SEL_TLBF:   tlbf_q   <= bus_wdata;
        SEL_PGF:    pgf_q    <= bus_wdata;
        SEL_ARBM:   arbm_q   <= apply_mask(bus_wdata, M_ARBM, F_ARBM);
        SEL_ARBSB:  arbsb_q  <= apply_mask(bus_wdata, M_ARBSB, F_ARBSB);
        SEL_MASKID: maskid_q <= apply_mask(bus_wdata, M_MASKID, maskid_q);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (bus_wr && sel == SEL_SLOT && bus_widx[SLOT_W-1:0] == SLOT_W'(g))
        slot_q[g] <= apply_mask(bus_wdata, M_SLOT, '0);
    end
  end

  for (genvar g = 0; g < SCRATCH_WORDS; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scratch_q[g] <= '0;
      else if (bus_wr && sel == SEL_SCRATCH && bus_widx[SCR_W-1:0] == SCR_W'(g))
        scratch_q[g] <= bus_wdata;
    end
  end

  assign tbl_base = base_q;

  always_comb begin
    case (sel)
      SEL_CTRL:    bus_rdata = ctrl_q;
      SEL_BASE:    bus_rdata = base_q;
      SEL_TLBF:    bus_rdata = tlbf_q;
      SEL_PGF:     bus_rdata = pgf_q;
      SEL_FSTAT:   bus_rdata = fstat_q;
      SEL_FADDR:   bus_rdata = faddr_q;
      SEL_ARBM:    bus_rdata = arbm_q;
      SEL_SLOT:    bus_rdata = slot_q[bus_widx[SLOT_W-1:0]];
      SEL_ARBSB:   bus_rdata = arbsb_q;
      SEL_MASKID:  bus_rdata = maskid_q;
      SEL_SCRATCH: bus_rdata = scratch_q[bus_widx[SCR_W-1:0]];
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xrf_chk.sv
module xrf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flt_valid,
  input logic        fault_touch,
  input logic        ctrl_wr,
  input logic        irq,
  input logic [31:0] win_start,
  input logic [31:0] fstat_q,
  input logic [31:0] arbm_q,
  input logic [31:0] arbsb_q,
  input logic [31:0] maskid_q
);
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_touch && !flt_valid) |=> !irq);

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> irq);

  // R3
  win_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (win_start[31] && win_start[23:0] == 24'h0));

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(win_start));

  // R5
  fstat_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fstat_q[23]);

  // R7
  arbm_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arbm_q[0]);

  // R9
  arbsb_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arbsb_q[3]);

  // R10
  maskid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((maskid_q & $past(maskid_q)) == $past(maskid_q)) &&
    (maskid_q[31:24] == $past(maskid_q[31:24])));
endmodule

bind xlat_ctl_regs xrf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flt_valid   (flt_valid),
  .fault_touch (fault_touch),
  .ctrl_wr     (ctrl_wr),
  .irq         (irq),
  .win_start   (win_start),
  .fstat_q     (fstat_q),
  .arbm_q      (arbm_q),
  .arbsb_q     (arbsb_q),
  .maskid_q    (maskid_q)
);

// File: tb/xlat_ctl_regs_tb_top.sv
module xlat_ctl_regs_tb_top;
  localparam logic [31:0] VER = 32'h0500_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_widx = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flt_valid = 1'b0, flt_write = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        irq;
  logic [31:0] win_start, tbl_base;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_ctl_regs #(.VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_widx(bus_widx), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flt_valid(flt_valid), .flt_write(flt_write), .flt_addr(flt_addr),
    .irq(irq), .win_start(win_start), .tbl_base(tbl_base)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(int boff, logic [31:0] d);
    @(negedge clk);
    bus_widx = 12'(boff >> 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Returns read data; the read strobe spans one edge.
  task automatic rd(int boff, output logic [31:0] d);
    @(negedge clk);
    bus_widx = 12'(boff >> 2); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Peek without a read strobe, so the interrupt is not disturbed.
  task automatic peek(int boff, output logic [31:0] d);
    @(negedge clk);
    bus_widx = 12'(boff >> 2);
    #1 d = bus_rdata;
  endtask

  task automatic capture(logic is_wr, logic [31:0] a);
    @(negedge clk);
    flt_valid = 1'b1; flt_write = is_wr; flt_addr = a;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek('h0000, v);    chk("R1 ctrl", v, VER & 32'hFF00_0000);
    peek('h1000, v);    chk("R1 fstat", v, 32'h0080_0000);
    peek('h1008, v);    chk("R1 arbm", v, 32'h0000_0003);
    peek('h2000, v);    chk("R1 arbsb", v, 32'h0000_0008);
    peek('h3018, v);    chk("R1 maskid", v, 32'h2300_0000);
    peek('h1010, v);    chk("R1 slot0", v, 32'h0);
    chk("R1 win_start", win_start, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_window;
    logic [31:0] v;
    wr('h0000, 32'hFFFF_FFFF);
    peek('h0000, v); chk("R2 ctrl mask", v, 32'h0500_001D);
    for (int c = 0; c < 8; c++) begin
      logic [63:0] e;
      wr('h0000, 32'(c << 2));
      e = 64'h1_0000_0000 - (64'd16777216 << c);
      chk($sformatf("R3 window code %0d", c), win_start, e[31:0]);
    end
    wr('h0004, 32'h0);
    chk("R3 window held on other write", win_start, 32'h8000_0000);
  endtask

  task automatic t_base_flush;
    logic [31:0] v;
    wr('h0004, 32'hFFFF_FFFF);
    peek('h0004, v); chk("R4 base mask", v, 32'h07FF_FC00);
    chk("R4 tbl_base", tbl_base, 32'h07FF_FC00);
    wr('h0014, 32'hDEAD_BEEF);
    peek('h0014, v); chk("R4 tlb flush", v, 32'hDEAD_BEEF);
    wr('h0018, 32'h1234_5678);
    peek('h0018, v); chk("R4 page flush", v, 32'h1234_5678);
  endtask

  task automatic t_fault_regs;
    logic [31:0] v;
    wr('h1000, 32'hFFFF_FFFF);
    peek('h1000, v); chk("R5 fstat ones", v, 32'hFF8F_FFFF);
    wr('h1000, 32'h0);
    peek('h1000, v); chk("R5 fstat zero", v, 32'h0080_0000);
    wr('h1004, 32'hA5A5_0F0F);
    peek('h1004, v); chk("R6 faddr", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_arb_slots;
    logic [31:0] v;
    wr('h1008, 32'hFFFF_FFFF);
    peek('h1008, v); chk("R7 arbm ones", v, 32'h801F_000F);
    wr('h1008, 32'h0);
    peek('h1008, v); chk("R7 arbm zero", v, 32'h0000_0001);
    wr('h1014, 32'hFFFF_FFFF);
    peek('h1014, v); chk("R8 slot1", v, 32'h0001_0003);
    peek('h1010, v); chk("R8 slot0 untouched", v, 32'h0);
    peek('h1018, v); chk("R8 slot2 untouched", v, 32'h0);
    wr('h101C, 32'h0000_0005);
    peek('h101C, v); chk("R8 slot3", v, 32'h0000_0001);
    wr('h2000, 32'hFFFF_FFFF);
    peek('h2000, v); chk("R9 arbsb ones", v, 32'h001F_0008);
    wr('h2000, 32'h0);
    peek('h2000, v); chk("R9 arbsb zero", v, 32'h0000_0008);
  endtask

  task automatic t_maskid;
    logic [31:0] v;
    wr('h3018, 32'h0000_0011);
    peek('h3018, v); chk("R10 or in", v, 32'h2300_0011);
    wr('h3018, 32'hFF00_0100);
    peek('h3018, v); chk("R10 high ignored", v, 32'h2300_0111);
    wr('h3018, 32'h0);
    peek('h3018, v); chk("R10 no clear", v, 32'h2300_0111);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    capture(1'b0, 32'h00AB_C000);
    chk("R11 irq set", {31'h0, irq}, 32'h1);
    peek('h1000, v); chk("R11 fstat read fault", v, 32'hC086_0000);
    chk("R11 irq kept by peek", {31'h0, irq}, 32'h1);
    rd('h1004, v);   chk("R11 faddr", v, 32'h00AB_C000);
    chk("R6 read clears irq", {31'h0, irq}, 32'h0);
    capture(1'b1, 32'h0012_3000);
    peek('h1000, v); chk("R11 fstat write fault", v, 32'hC082_0000);
    wr('h1004, 32'h0);
    chk("R6 write clears irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    flt_valid = 1'b1; flt_write = 1'b1; flt_addr = 32'h0F0F_0000;
    bus_widx = 12'h400; bus_wdata = 32'h0; bus_wr = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; bus_wr = 1'b0;
    chk("R11 collide irq", {31'h0, irq}, 32'h1);
    peek('h1000, v); chk("R11 collide fstat", v, 32'hC082_0000);
    @(negedge clk);
    flt_valid = 1'b1; flt_write = 1'b0; flt_addr = 32'h7777_0000;
    bus_widx = 12'h401; bus_rd = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; bus_rd = 1'b0;
    chk("R11 capture beats read clear", {31'h0, irq}, 32'h1);
    rd('h1000, v);   chk("R11 collide fstat read", v, 32'hC086_0000);
    chk("R6 clear after collide", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_scratch;
    logic [31:0] v;
    wr('h0008, 32'hCAFE_F00D);
    peek('h0008, v); chk("R12 scratch store", v, 32'hCAFE_F00D);
    wr('h003C, 32'h0BAD_0001);
    peek('h003C, v); chk("R12 scratch last", v, 32'h0BAD_0001);
    wr('h2004, 32'hFFFF_FFFF);
    peek('h2004, v); chk("R12 unmapped reads zero", v, 32'h0);
    peek('h0008, v); chk("R12 scratch unaffected", v, 32'hCAFE_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_window();
    t_base_flush();
    t_fault_regs();
    t_arb_slots();
    t_maskid();
    t_capture();
    t_collide();
    t_scratch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule